// File: doc/BRIEF.md
# Root-Port Legacy Interrupt Queue

This block gathers legacy INTx assert and deassert events from the four interrupt lines behind a PCI Express root port. Each event becomes one entry of a small circular queue. Software drains the queue through a narrow register port. It reads the head entry as two 32-bit words, and it removes that entry by writing to either word's address.

Beside the queue, the register port exposes four more registers. The interrupt status register carries a summary INTx bit. The interrupt enable register is 32 bits of plain storage. The link register reflects a link-up input. The port control register holds a bridge-enable bit, a queue-occupancy flag and a sticky overflow flag. One level-sensitive interrupt output is high whenever an enabled status bit is set.

The register port takes a one-cycle request strobe with a 12-bit byte address, a write flag and 32-bit write data. Read data appears registered in the cycle after the request. The queue holds DEPTH-1 entries, because one slot always stays empty to tell full from empty.

Top module: `rp_intx_queue`

## Requirements
- R1: After reset the status, enable and control registers, both queue words, the read data, `irq_o` and `bridge_en_o` are all zero.
- R2: Reading address 0x144 returns bit 11 equal to `link_up_i` and all other bits zero.
- R3: An accepted event stores an entry whose first word (address 0x158) has the line number in bits 28:27, the level (1 assert, 0 deassert) in bit 29 and a 1 in bit 31, with all other bits zero. The second word (address 0x15C) always reads zero.
- R4: Entries leave the queue in arrival order, and reading a queue word does not remove the head entry.
- R5: A write of any data to 0x158 or 0x15C removes the head entry, with the pointer wrapping at DEPTH. On an empty queue such a write has no effect.
- R6: The queue holds at most DEPTH-1 entries. An event arriving while it is full is discarded and sets control bit 19. Bit 19 stays set until software writes 1 to bit 19 of the control register (0x148).
- R7: Control register bit 0 is read/write and drives `bridge_en_o`. Bit 18 reads 1 exactly when the queue is non-empty. A control write changes no bit other than 0 and 19.
- R8: Status register (0x138) bit 16 is set by every accepted event and cleared by writing 1 to it, but it reads 1 while the queue is non-empty. Bit 17 and all other status bits read zero.
- R9: The enable register (0x13C) stores and returns all 32 written bits.
- R10: `irq_o` is high exactly when the bitwise AND of the status and enable registers is nonzero.
- R11: Read data is valid in the cycle after a read request and holds otherwise. Reads of any address other than the six mapped ones return zero.
- R12: Reading either queue word while the queue is empty returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up_i | input | 1 | Link-up indication from the PHY |
| evt_valid_i | input | 1 | Legacy interrupt event strobe |
| evt_line_i | input | 2 | Interrupt line of the event (0..3) |
| evt_level_i | input | 1 | 1 for assert, 0 for deassert |
| reg_valid_i | input | 1 | Register request strobe |
| reg_write_i | input | 1 | 1 for write, 0 for read |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt output |
| bridge_en_o | output | 1 | Bridge enable from control bit 0 |

## Verification
The bench builds the block with DEPTH set to 4, so the queue fills after three events. Overflow, dropped events and sticky flag clearing are then only a few requests away. An eight-event sweep over every line and level pair wraps both pointers twice. Every entry is checked against its arithmetically computed word, and the pops alternate between the two queue addresses.

// File: rtl/rpq_pkg.sv
package rpq_pkg;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_STATUS = 12'h138;
  localparam logic [ADDR_W-1:0] A_ENABLE = 12'h13C;
  localparam logic [ADDR_W-1:0] A_LINK   = 12'h144;
  localparam logic [ADDR_W-1:0] A_CTRL   = 12'h148;
  localparam logic [ADDR_W-1:0] A_QWORD1 = 12'h158;
  localparam logic [ADDR_W-1:0] A_QWORD2 = 12'h15C;

  localparam int B_INTX    = 16;
  localparam int B_LINKUP  = 11;
  localparam int B_BRIDGE  = 0;
  localparam int B_NEMPTY  = 18;
  localparam int B_OVF     = 19;
  localparam int B_LINE    = 27;
  localparam int B_LEVEL   = 29;
  localparam int B_VALID   = 31;

  typedef struct packed {
    logic [1:0] line;
    logic       level;
  } evt_t;

  function automatic logic [DATA_W-1:0] entry_word1(evt_t e);
    logic [DATA_W-1:0] w;
    w = '0;
    w[B_LINE +: 2] = e.line;
    w[B_LEVEL]     = e.level;
    w[B_VALID]     = 1'b1;
    return w;
  endfunction

  function automatic logic addr_mapped(logic [ADDR_W-1:0] a);
    return (a == A_STATUS) || (a == A_ENABLE) || (a == A_LINK) ||
           (a == A_CTRL) || (a == A_QWORD1) || (a == A_QWORD2);
  endfunction

endpackage

// File: rtl/rpq_fifo.sv
module rpq_fifo
  import rpq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push_i,
  input  evt_t push_evt_i,
  input  logic pop_i,
  output logic push_ok_o,
  output logic drop_o,
  output logic empty_o,
  output evt_t head_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wptr_q, wptr_d, wptr_inc;
  logic [PTR_W-1:0] rptr_q, rptr_d, rptr_inc;
  logic             full, pop_ok;
  evt_t             mem_q [DEPTH];

  always_comb begin
    wptr_inc  = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
    rptr_inc  = (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
    empty_o   = (wptr_q == rptr_q);
    full      = (wptr_inc == rptr_q);
    push_ok_o = push_i && !full;
    drop_o    = push_i && full;
    pop_ok    = pop_i && !empty_o;
    wptr_d    = push_ok_o ? wptr_inc : wptr_q;
    rptr_d    = pop_ok ? rptr_inc : rptr_q;
    head_o    = mem_q[rptr_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok_o) begin
      mem_q[wptr_q] <= push_evt_i;
    end
  end

endmodule

// File: rtl/rpq_regs.sv
module rpq_regs
  import rpq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_status_i,
  input  logic              wr_enable_i,
  input  logic              wr_ctrl_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              push_ok_i,
  input  logic              drop_i,
  input  logic              fifo_empty_i,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] enable_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              bridge_en_o,
  output logic              irq_o
);

  logic              intx_q, intx_d;
  logic              ovf_q, ovf_d;
  logic              bridge_q, bridge_d;
  logic [DATA_W-1:0] enable_q, enable_d;

  always_comb begin
    intx_d   = (intx_q && !(wr_status_i && wdata_i[B_INTX])) || push_ok_i;
    ovf_d    = (ovf_q && !(wr_ctrl_i && wdata_i[B_OVF])) || drop_i;
    bridge_d = wr_ctrl_i ? wdata_i[B_BRIDGE] : bridge_q;
    enable_d = wr_enable_i ? wdata_i : enable_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intx_q   <= 1'b0;
      ovf_q    <= 1'b0;
      bridge_q <= 1'b0;
      enable_q <= '0;
    end else begin
      intx_q   <= intx_d;
      ovf_q    <= ovf_d;
      bridge_q <= bridge_d;
      enable_q <= enable_d;
    end
  end

  always_comb begin
    status_o           = '0;
    status_o[B_INTX]   = intx_q || !fifo_empty_i;
    enable_o           = enable_q;
    ctrl_o             = '0;
    ctrl_o[B_BRIDGE]   = bridge_q;
    ctrl_o[B_NEMPTY]   = !fifo_empty_i;
    ctrl_o[B_OVF]      = ovf_q;
    bridge_en_o        = bridge_q;
    irq_o              = |(status_o & enable_q);
  end

endmodule

// File: rtl/rpq_rdmux.sv
module rpq_rdmux
  import rpq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              link_up_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] enable_i,
  input  logic [DATA_W-1:0] ctrl_i,
  input  logic              fifo_empty_i,
  input  evt_t              head_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] rd_d, rdata_q;

  always_comb begin
    rd_d = '0;
    unique case (addr_i)
      A_STATUS: rd_d = status_i;
      A_ENABLE: rd_d = enable_i;
      A_LINK:   rd_d[B_LINKUP] = link_up_i;
      A_CTRL:   rd_d = ctrl_i;
      A_QWORD1: rd_d = fifo_empty_i ? '0 : entry_word1(head_i);
      A_QWORD2: rd_d = '0;
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_req_i) begin
      rdata_q <= rd_d;
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/rp_intx_queue.sv
module rp_intx_queue
  import rpq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        link_up_i,
  input  logic        evt_valid_i,
  input  logic [1:0]  evt_line_i,
  input  logic        evt_level_i,
  input  logic        reg_valid_i,
  input  logic        reg_write_i,
  input  logic [11:0] reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o,
  output logic        bridge_en_o
);

  logic       rst_meta_q, rst_core_n;
  logic       wr, rd;
  logic       push_ok, drop, fifo_empty;
  evt_t       push_evt, head;
  logic [DATA_W-1:0] status, enable, ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  always_comb begin
    wr             = reg_valid_i && reg_write_i;
    rd             = reg_valid_i && !reg_write_i;
    push_evt.line  = evt_line_i;
    push_evt.level = evt_level_i;
  end

  rpq_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .push_i     (evt_valid_i),
    .push_evt_i (push_evt),
    .pop_i      (wr && ((reg_addr_i == A_QWORD1) || (reg_addr_i == A_QWORD2))),
    .push_ok_o  (push_ok),
    .drop_o     (drop),
    .empty_o    (fifo_empty),
    .head_o     (head)
  );

  rpq_regs i_regs (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .wr_status_i  (wr && (reg_addr_i == A_STATUS)),
    .wr_enable_i  (wr && (reg_addr_i == A_ENABLE)),
    .wr_ctrl_i    (wr && (reg_addr_i == A_CTRL)),
    .wdata_i      (reg_wdata_i),
    .push_ok_i    (push_ok),
    .drop_i       (drop),
    .fifo_empty_i (fifo_empty),
    .status_o     (status),
    .enable_o     (enable),
    .ctrl_o       (ctrl),
    .bridge_en_o  (bridge_en_o),
    .irq_o        (irq_o)
  );

  rpq_rdmux i_rdmux (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .rd_req_i     (rd),
    .addr_i       (reg_addr_i),
    .link_up_i    (link_up_i),
    .status_i     (status),
    .enable_i     (enable),
    .ctrl_i       (ctrl),
    .fifo_empty_i (fifo_empty),
    .head_i       (head),
    .rdata_o      (reg_rdata_o)
  );

endmodule

// File: rtl/rp_intx_queue_chk.sv
module rp_intx_queue_chk
  import rpq_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        link_up_i,
  input logic        reg_valid_i,
  input logic        reg_write_i,
  input logic [11:0] reg_addr_i,
  input logic [31:0] reg_wdata_i,
  input logic [31:0] reg_rdata_o,
  input logic        bridge_en_o
);

  logic rd_req, wr_ctrl;
  assign rd_req  = reg_valid_i && !reg_write_i;
  assign wr_ctrl = reg_valid_i && reg_write_i && (reg_addr_i == A_CTRL);

  p_bridge_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (bridge_en_o == $past(reg_wdata_i[B_BRIDGE])));

  p_bridge_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(bridge_en_o));

  p_link_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && reg_addr_i == A_LINK) |=>
      (reg_rdata_o == (32'($past(link_up_i)) << B_LINKUP)));

  p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !addr_mapped(reg_addr_i)) |=> (reg_rdata_o == '0));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(reg_rdata_o));

  p_word2_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && reg_addr_i == A_QWORD2) |=> (reg_rdata_o == '0));

  p_word1_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && reg_addr_i == A_QWORD1) |=>
      ((reg_rdata_o == '0) || reg_rdata_o[B_VALID]));

endmodule

bind rp_intx_queue rp_intx_queue_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .link_up_i   (link_up_i),
  .reg_valid_i (reg_valid_i),
  .reg_write_i (reg_write_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .bridge_en_o (bridge_en_o)
);

// File: tb/test_rp_intx_queue.sv
module test_rp_intx_queue;

  localparam int CLK_PERIOD = 10;
  localparam int QDEPTH     = 4;

  localparam logic [11:0] STATUS = 12'h138;
  localparam logic [11:0] ENABLE = 12'h13C;
  localparam logic [11:0] LINK   = 12'h144;
  localparam logic [11:0] CTRL   = 12'h148;
  localparam logic [11:0] QW1    = 12'h158;
  localparam logic [11:0] QW2    = 12'h15C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_up_i = 1'b0;
  logic        evt_valid_i = 1'b0;
  logic [1:0]  evt_line_i = '0;
  logic        evt_level_i = 1'b0;
  logic        reg_valid_i = 1'b0;
  logic        reg_write_i = 1'b0;
  logic [11:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;
  logic        bridge_en_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rp_intx_queue #(.DEPTH(QDEPTH)) i_rp_intx_queue (
    .clk(clk), .rst_n(rst_n), .link_up_i(link_up_i),
    .evt_valid_i(evt_valid_i), .evt_line_i(evt_line_i), .evt_level_i(evt_level_i),
    .reg_valid_i(reg_valid_i), .reg_write_i(reg_write_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o),
    .bridge_en_o(bridge_en_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_valid_i = 1'b1; reg_write_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_valid_i = 1'b0; reg_write_i = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_valid_i = 1'b1; reg_write_i = 1'b0; reg_addr_i = a;
    @(negedge clk);
    reg_valid_i = 1'b0;
    d = reg_rdata_o;
  endtask

  task automatic evt(int line, int level);
    @(negedge clk);
    evt_valid_i = 1'b1; evt_line_i = 2'(line); evt_level_i = level[0];
    @(negedge clk);
    evt_valid_i = 1'b0;
  endtask

  function automatic logic [31:0] word1(int line, int level);
    return (32'd1 << 31) | (32'(level) << 29) | (32'(line) << 27);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 rdata", reg_rdata_o, 0);
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 bridge", 32'(bridge_en_o), 0);
    rd(STATUS, d); chk("R1 status", d, 0);
    rd(ENABLE, d); chk("R1 enable", d, 0);
    rd(CTRL, d);   chk("R1 ctrl", d, 0);
    rd(QW1, d);    chk("R12 empty word1", d, 0);
    rd(QW2, d);    chk("R12 empty word2", d, 0);

    // R2 link bit
    rd(LINK, d); chk("R2 link down", d, 0);
    link_up_i = 1'b1;
    rd(LINK, d); chk("R2 link up", d, 32'h800);

    // R11 unmapped, R9 enable storage
    rd(12'h000, d); chk("R11 unmapped 0x000", d, 0);
    rd(12'h140, d); chk("R11 unmapped 0x140", d, 0);
    rd(12'hFFC, d); chk("R11 unmapped 0xFFC", d, 0);
    wr(ENABLE, 32'hA5C3_0F96); rd(ENABLE, d); chk("R9 enable pattern", d, 32'hA5C3_0F96);
    wr(ENABLE, 32'hFFFF_FFFF); rd(ENABLE, d); chk("R9 enable ones", d, 32'hFFFF_FFFF);
    wr(ENABLE, 32'h0);         rd(ENABLE, d); chk("R9 enable zero", d, 0);

    // R5 pop on empty queue ignored
    wr(QW1, 32'hFFFF_FFFF);
    rd(CTRL, d); chk("R5 empty pop ctrl", d, 0);
    evt(2, 1);
    rd(QW1, d); chk("R5 after empty pop", d, word1(2, 1));
    wr(QW1, 0);
    rd(QW1, d); chk("R5 popped", d, 0);

    // Sweep all lines and levels, pointers wrap twice
    for (int i = 0; i < 8; i++) begin
      int ln, lv;
      ln = i % 4; lv = (i / 4) % 2;
      evt(ln, lv);
      rd(QW1, d);  chk("R3 word1 encoding", d, word1(ln, lv));
      rd(QW1, d);  chk("R4 peek keeps head", d, word1(ln, lv));
      rd(QW2, d);  chk("R3 word2 zero", d, 0);
      rd(CTRL, d); chk("R7 nonempty flag", d, 32'h4_0000);
      rd(STATUS, d); chk("R8 status forced", d, 32'h1_0000);
      wr((i % 2) ? QW2 : QW1, 32'h0);
      rd(QW1, d);  chk("R12 drained word1", d, 0);
      rd(CTRL, d); chk("R7 empty flag", d, 0);
    end

    // R8 sticky summary bit and write-one-to-clear
    rd(STATUS, d); chk("R8 sticky after drain", d, 32'h1_0000);
    wr(STATUS, 32'hFFFE_FFFF); rd(STATUS, d); chk("R8 zero write no clear", d, 32'h1_0000);
    wr(STATUS, 32'h1_0000);    rd(STATUS, d); chk("R8 w1c", d, 0);
    evt(1, 0);
    wr(STATUS, 32'h1_0000);    rd(STATUS, d); chk("R8 forced while queued", d, 32'h1_0000);

    // R10 interrupt output
    chk("R10 masked", 32'(irq_o), 0);
    wr(ENABLE, 32'h2_0000); chk("R10 other bit enabled", 32'(irq_o), 0);
    wr(ENABLE, 32'h1_0000); chk("R10 enabled", 32'(irq_o), 1);
    wr(QW2, 0);
    rd(STATUS, d); chk("R8 cleared on drain", d, 0);
    chk("R10 drop after drain", 32'(irq_o), 0);
    evt(3, 1); chk("R10 rise on event", 32'(irq_o), 1);
    wr(QW1, 0); chk("R10 sticky keeps irq", 32'(irq_o), 1);
    wr(STATUS, 32'h1_0000); chk("R10 clear", 32'(irq_o), 0);
    wr(ENABLE, 0);

    // R6 full and overflow
    evt(1, 1); evt(2, 0); evt(3, 1);
    rd(CTRL, d); chk("R6 full no overflow", d, 32'h4_0000);
    evt(0, 0);
    rd(CTRL, d); chk("R6 overflow set", d, 32'hC_0000);
    rd(QW1, d); chk("R4 order 1", d, word1(1, 1)); wr(QW1, 0);
    rd(QW1, d); chk("R4 order 2", d, word1(2, 0)); wr(QW2, 0);
    rd(QW1, d); chk("R4 order 3", d, word1(3, 1)); wr(QW1, 0);
    rd(QW1, d); chk("R6 dropped event absent", d, 0);
    rd(CTRL, d); chk("R6 overflow sticky", d, 32'h8_0000);
    wr(CTRL, 32'h0);       rd(CTRL, d); chk("R6 zero keeps overflow", d, 32'h8_0000);
    wr(CTRL, 32'h8_0000);  rd(CTRL, d); chk("R6 overflow cleared", d, 0);

    // R7 bridge enable and ignored bits
    wr(CTRL, 32'hFFFF_FFFF);
    rd(CTRL, d); chk("R7 only bit0 set", d, 32'h1);
    chk("R7 bridge out high", 32'(bridge_en_o), 1);
    wr(CTRL, 32'h4_0000);
    rd(CTRL, d); chk("R7 bridge cleared", d, 0);
    chk("R7 bridge out low", 32'(bridge_en_o), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule